// File: doc/BRIEF.md
# Synchronous Power-of-Two Clock Divider

This block takes one input clock and produces divided clocks at one half, one quarter and one eighth of the input rate. Every divider stage is clocked by the same gated internal clock and forms one bit of a synchronous binary counter. Edges that two or more outputs share therefore fall on the same input edge.

A freeze input stops the internal clock and later restarts it. The freeze request is captured on the falling edge of the input clock, so the gate only opens or closes while the input clock is low. This means freezing and resuming never produce a short internal clock pulse, and the counter resumes exactly where it stopped.

An asynchronous active-low master reset clears every stage. It also clears the captured freeze state. One reset line can therefore align any number of instances. The gated internal clock is also brought out, so a neighbour can clock from it or watch it.

Top module: `clk_div_pow2`

## Requirements
- R1: `div_out[0]` has a period of 2 input clock cycles while the block runs freely.
- R2: `div_out[1]` has a period of 4 input clock cycles and `div_out[2]` has a period of 8 input clock cycles while the block runs freely.
- R3: `div_out` read as an unsigned number (bit 0 = divide by 2) increases by one, modulo 8, on each rising input edge that is not frozen. All outputs change only just after a rising input edge. At the wrap from 7 to 0, all three outputs fall on the same edge.
- R4: `freeze` is active-high. If it is high at a falling input edge, the next rising input edge is suppressed and `div_out` holds its value.
- R5: The gated clock `gclk_out` changes state only while the input clock is low. No high or low phase of it is shorter than half an input period, for any length of freeze.
- R6: After a freeze of any length, the output sequence continues from the held value exactly as if the frozen cycles had not occurred.
- R7: While `mrst_n` is low, `div_out` is 0 immediately, whatever the clock and `freeze` are doing.
- R8: Reset clears the captured freeze state to running. With `freeze` low when reset is released, the first rising input edge after release sets `div_out` to 1.
- R9: `gclk_out` stays low across every input clock cycle that is frozen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| freeze | input | 1 | Freeze request, active high, sampled on falling clk_in |
| div_out | output | NUM_STAGES (3) | Divided clocks; bit i runs at clk_in / 2^(i+1) |
| gclk_out | output | 1 | Gated internal clock that drives all stages |

## Verification
The hardest situation to reach from the ports is a freeze request or a reset that arrives while the input clock is high. In that case a badly placed gate would cut a clock pulse short. The stimulus changes `freeze` just after rising edges, holds freezes of one cycle and of several cycles, and applies reset in the middle of a high phase while frozen. A monitor then measures every high and low phase of `gclk_out` that starts outside reset. A vector table walks the counter through freezes, through the wrap, and through the restart. Directed tests then measure the output periods and check that the outputs fall together at the wrap.

// File: rtl/clkdiv_pkg.sv
// Package: shared types and defaults for the power-of-two clock divider.
// Assumes: nothing beyond IEEE 1800-2017.
package clkdiv_pkg;

    // Default number of divider stages (divide by 2, 4, 8).
    parameter int unsigned CDV_STAGES_DEFAULT = 3;

    // State held by the falling-edge freeze capture flop.
    typedef enum logic {
        CDV_RUN    = 1'b0,
        CDV_FROZEN = 1'b1
    } run_state_e;

endpackage : clkdiv_pkg

// File: rtl/cdv_freeze_capture.sv
// Module: captures the freeze request on the falling edge of the input clock.
// It does this so the gate after it only changes while the input clock is low.
// Assumes: freeze meets setup and hold around the falling edge. Reset is
// asynchronous and active low, and it returns the state to running.
module cdv_freeze_capture
    import clkdiv_pkg::*;
(
    input  logic       clk_in,
    input  logic       mrst_n,
    input  logic       freeze,
    output run_state_e state_q
);

    // Sample the request on the falling edge; reset forces the running state.
    always_ff @(negedge clk_in or negedge mrst_n) begin
        if (!mrst_n) begin
            state_q <= CDV_RUN;
        end else begin
            state_q <= freeze ? CDV_FROZEN : CDV_RUN;
        end
    end

endmodule : cdv_freeze_capture

// File: rtl/cdv_clock_gate.sv
// Module: AND-style clock gate for the internal divider clock.
// Assumes: the enable changes only while clk_in is low, so the output is
// glitch free without a latch. The enable comes from a falling-edge flop.
module cdv_clock_gate (
    input  logic clk_in,
    input  logic gate_en,
    output logic gclk
);

    // Pass the input clock only while the captured enable is high.
    always_comb begin
        gclk = clk_in & gate_en;
    end

endmodule : cdv_clock_gate

// File: rtl/cdv_div_stage.sv
// Module: one synchronous divider stage, which is one bit of a binary counter.
// The bit toggles on the gated clock when its carry-in is high. It passes
// carry_in & q on to the next stage.
// Assumes: every stage shares the same gated clock and the same
// asynchronous active-low reset.
module cdv_div_stage (
    input  logic gclk,
    input  logic mrst_n,
    input  logic carry_in,
    output logic q,
    output logic carry_out
);

    // Toggle when all lower stages are high; reset clears the bit.
    always_ff @(posedge gclk or negedge mrst_n) begin
        if (!mrst_n) begin
            q <= 1'b0;
        end else if (carry_in) begin
            q <= ~q;
        end
    end

    // Ripple the toggle condition combinationally to the next stage.
    always_comb begin
        carry_out = carry_in & q;
    end

endmodule : cdv_div_stage

// File: rtl/clk_div_pow2.sv
// Module: top of the power-of-two clock divider. A falling-edge freeze
// capture drives an AND clock gate. All divider stages run from the gate
// output, which keeps the divided clocks phase aligned.
// Assumes: clk_in runs at about 50 % duty. mrst_n is asynchronous and
// active low. freeze is active high.
module clk_div_pow2
    import clkdiv_pkg::*;
#(
    parameter int unsigned NUM_STAGES = CDV_STAGES_DEFAULT
) (
    input  logic                  clk_in,
    input  logic                  mrst_n,
    input  logic                  freeze,
    output logic [NUM_STAGES-1:0] div_out,
    output logic                  gclk_out
);

    localparam int unsigned CARRY_W = NUM_STAGES;

    run_state_e            state_q;
    logic                  frz_q;
    logic                  gclk;
    logic [CARRY_W-1:0]    carry;
    logic [NUM_STAGES-1:0] stage_q;

    // Falling-edge capture of the freeze request.
    cdv_freeze_capture u_capture (
        .clk_in  (clk_in),
        .mrst_n  (mrst_n),
        .freeze  (freeze),
        .state_q (state_q)
    );

    // Decode the captured state for the gate and the checker.
    always_comb begin
        frz_q = (state_q == CDV_FROZEN);
    end

    // Gate the input clock while frozen.
    cdv_clock_gate u_gate (
        .clk_in  (clk_in),
        .gate_en (~frz_q),
        .gclk    (gclk)
    );

    assign carry[0] = 1'b1;

    // Chain of synchronous toggle stages; the last carry-out is not used.
    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        logic co;
        cdv_div_stage u_stage (
            .gclk      (gclk),
            .mrst_n    (mrst_n),
            .carry_in  (carry[i]),
            .q         (stage_q[i]),
            .carry_out (co)
        );
        if (i < NUM_STAGES - 1) begin : g_link
            assign carry[i+1] = co;
        end else begin : g_end
            logic unused_co;
            assign unused_co = co;
        end
    end

    // Drive the ports.
    assign div_out  = stage_q;
    assign gclk_out = gclk;

endmodule : clk_div_pow2

// File: rtl/cdv_checker.sv
// Module: assertion checker for clk_div_pow2, attached through bind.
// Assumes: frz_q is the top's decoded falling-edge freeze state.
module cdv_checker #(
    parameter int unsigned NUM_STAGES = 3
) (
    input logic                  clk_in,
    input logic                  mrst_n,
    input logic                  frz_q,
    input logic [NUM_STAGES-1:0] div_out,
    input logic                  gclk_out
);

    // R3: a running edge advances the count by one, modulo 2^NUM_STAGES.
    p_count_step_r3: assert property (@(posedge clk_in) disable iff (!mrst_n)
        !frz_q |=> div_out == NUM_STAGES'($past(div_out) + 1'b1));

    // R1: a running edge always toggles the divide-by-2 output.
    p_div2_toggle_r1: assert property (@(posedge clk_in) disable iff (!mrst_n)
        !frz_q |=> div_out[0] != $past(div_out[0]));

    // R4 and R6: a frozen edge leaves every stage unchanged.
    p_freeze_hold_r4: assert property (@(posedge clk_in) disable iff (!mrst_n)
        frz_q |=> $stable(div_out));

    // R5 and R9: the gated clock rises only while the captured state is running.
    p_gclk_gated_r5: assert property (@(posedge gclk_out) disable iff (!mrst_n)
        !frz_q);

    // R7: reset holds every output low.
    p_reset_low_r7: assert property (@(negedge clk_in)
        !mrst_n |-> div_out == '0);

endmodule : cdv_checker

bind clk_div_pow2 cdv_checker #(.NUM_STAGES(NUM_STAGES)) u_chk (
    .clk_in   (clk_in),
    .mrst_n   (mrst_n),
    .frz_q    (frz_q),
    .div_out  (div_out),
    .gclk_out (gclk_out)
);

// File: tb/sim_clk_div_pow2.sv
`timescale 1ns/1ps
// Bench for clk_div_pow2: a vector table first, then directed tests.
module sim_clk_div_pow2;

    localparam realtime TCLK = 8.0;   // 125 MHz
    localparam int      NV   = 20;

    // Each entry is {freeze applied this cycle, expected div_out after the edge}.
    localparam logic [3:0] VEC [NV] = '{
        4'b0_001, 4'b0_010, 4'b0_011, 4'b0_100, 4'b1_100,
        4'b1_100, 4'b0_101, 4'b0_110, 4'b0_111, 4'b0_000,
        4'b1_000, 4'b0_001, 4'b1_001, 4'b1_001, 4'b1_001,
        4'b0_010, 4'b0_011, 4'b0_100, 4'b0_101, 4'b0_110
    };

    logic       clk_in = 1'b0;
    logic       mrst_n = 1'b0;
    logic       freeze = 1'b0;
    logic [2:0] div_out;
    logic       gclk_out;

    int  n_chk  = 0;
    int  n_fail = 0;
    int  n_runt = 0;
    int  n_gpos = 0;
    bit  done   = 1'b0;

    realtime t_rise = 0.0;
    realtime t_fall = -100.0;
    bit      rise_ok = 1'b0;

    clk_div_pow2 u0 (
        .clk_in   (clk_in),
        .mrst_n   (mrst_n),
        .freeze   (freeze),
        .div_out  (div_out),
        .gclk_out (gclk_out)
    );

    always #(TCLK/2) clk_in = ~clk_in;

    // Phase-width monitor on the gated clock (R5), ignoring pulses that start in reset.
    always @(posedge gclk_out) begin
        n_gpos++;
        rise_ok = mrst_n;
        if (mrst_n && ($realtime - t_fall) < (TCLK/2 - 0.1)) n_runt++;
        t_rise = $realtime;
    end
    always @(negedge gclk_out) begin
        if (rise_ok && mrst_n && ($realtime - t_rise) < (TCLK/2 - 0.1)) n_runt++;
        t_fall = $realtime;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(TCLK * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
        end
    end

    initial begin
        realtime ta, tb;
        int      g0;

        // Reset state (R7).
        #(TCLK * 2 + 1.0);
        check(div_out == 3'd0, "R7 reset state", div_out, 0);

        // Release reset just after a rising edge, with freeze low (R8).
        @(posedge clk_in); #2;
        mrst_n = 1'b1;

        // Vector table (R3, R4, R6, R8): set freeze before the falling edge, sample after the rising edge.
        for (int i = 0; i < NV; i++) begin
            freeze = VEC[i][3];
            @(posedge clk_in); #2;
            check(div_out == VEC[i][2:0],
                  (i == 0) ? "R8 first edge after reset" :
                  VEC[i][3] ? "R4 hold while frozen" : "R3/R6 count step",
                  div_out, VEC[i][2:0]);
        end
        freeze = 1'b0;

        // Periods (R1, R2).
        @(posedge div_out[0]); ta = $realtime;
        @(posedge div_out[0]); tb = $realtime;
        check((tb - ta) > 15.9 && (tb - ta) < 16.1, "R1 div2 period ns", int'(tb - ta), 16);
        @(posedge div_out[1]); ta = $realtime;
        @(posedge div_out[1]); tb = $realtime;
        check((tb - ta) > 31.9 && (tb - ta) < 32.1, "R2 div4 period ns", int'(tb - ta), 32);
        @(posedge div_out[2]); ta = $realtime;
        @(posedge div_out[2]); tb = $realtime;
        check((tb - ta) > 63.9 && (tb - ta) < 64.1, "R2 div8 period ns", int'(tb - ta), 64);

        // Shared falling edge at the wrap, just after a rising input edge (R3).
        @(negedge div_out[2]); #0.1;
        check(div_out == 3'd0, "R3 common fall at wrap", div_out, 0);
        check(clk_in == 1'b1, "R3 change follows rising input edge", clk_in, 1);

        // Long freeze: no gated pulses and the outputs held (R9, R4).
        @(posedge clk_in); #2;
        freeze = 1'b1;
        @(posedge clk_in); #2;
        g0 = n_gpos;
        ta = div_out;
        repeat (7) @(posedge clk_in);
        #2;
        check(n_gpos == g0, "R9 no gated pulse while frozen", n_gpos - g0, 0);
        check(div_out == 3'(int'(ta)), "R4 hold over long freeze", div_out, int'(ta));
        freeze = 1'b0;
        @(posedge clk_in); #2;
        check(div_out == 3'(int'(ta) + 1), "R6 resume after long freeze", div_out, int'(ta) + 1);

        // Reset in the middle of a high phase while frozen (R7), released while frozen (R8, R4).
        freeze = 1'b1;
        @(posedge clk_in); #1;
        mrst_n = 1'b0;
        #0.5;
        check(div_out == 3'd0, "R7 asynchronous clear while frozen", div_out, 0);
        repeat (2) @(posedge clk_in);
        #2;
        check(div_out == 3'd0, "R7 held low during reset", div_out, 0);
        mrst_n = 1'b1;
        repeat (2) @(posedge clk_in);
        #2;
        check(div_out == 3'd0, "R4 frozen across reset release", div_out, 0);
        freeze = 1'b0;
        @(posedge clk_in); #2;
        check(div_out == 3'd1, "R6 first count after frozen release", div_out, 1);

        // Single-cycle freezes repeated (R6), then the runt summary (R5).
        for (int k = 0; k < 4; k++) begin
            freeze = 1'b1;
            @(posedge clk_in); #2;
            freeze = 1'b0;
            @(posedge clk_in); #2;
        end
        check(div_out == 3'd5, "R6 count after alternating freezes", div_out, 5);
        check(n_runt == 0, "R5 gated clock phase widths", n_runt, 0);

        done = 1'b1;
        summary();
    end

endmodule : sim_clk_div_pow2